// File: doc/BRIEF.md
# Multicycle Fetch-Execute Sequencer

This block is the control core of a small 16-bit processor that shares one path between its registers. It holds the memory address register, the memory data register, the instruction register, the program counter, eight general registers and a three-flag condition register (negative, zero, positive). A finite-state controller moves each instruction through a fixed series of phases: fetch, decode, address evaluation, an optional pointer read, operand access, and result write-back. In every phase it drives the load enables, the multiplexer selects and the memory strobes. The controller spends exactly one state on each memory access.

The supported instructions are add, bitwise and, bitwise not, direct, indirect and base-plus-offset loads and stores, load-effective-address, and the conditional branch. A trap with vector x25 stops the sequencer. Other trap vectors and the unused opcodes do nothing and execution moves on to the next instruction.

The memory port has no valid/ready handshake, because a single-cycle synchronous word memory cannot stall. The read strobe lasts one cycle, and the read data must be valid in the following cycle. A write strobe presents the address and the data in the same cycle, and the write completes at that edge. The block never applies back-pressure and never accepts any.

Top module: `fx_core`

## Requirements
- R1: While reset is held, `mem_rd`, `mem_wr` and `halted` are low. Reset clears all eight registers and sets the flags to zero-only. The first read after reset is at address x0000, and each fetch increments the program counter.
- R2: Each memory strobe lasts exactly one cycle. The two strobes are never high together. The instruction word is taken from `mem_rdata` one cycle after the read strobe.
- R3: Operate instructions name the destination in bits [11:9] and the first source in bits [8:6]. Add (opcode 0001) and and (0101) take a second register from bits [2:0] when bit 5 is 0. When bit 5 is 1, they take bits [4:0] sign-extended. Not (1001) writes the ones' complement of the first source.
- R4: Direct load (0010) and direct store (0011) use the address formed by the upper seven bits of the already-incremented program counter, joined with bits [8:0]. The store source register is in bits [11:9].
- R5: Base-plus-offset load (0110) and store (0111) use the register in bits [8:6] plus bits [5:0] zero-extended.
- R6: Indirect load (1010) and indirect store (1011) first read a pointer at the direct address, then access the operand at that pointer. The pointer word itself is never written.
- R7: Load-effective-address (1110) writes the direct address into the destination and performs no memory access.
- R8: Every register write sets exactly one flag from the value written: negative when bit 15 is set, zero when the value is zero, positive otherwise. Stores and branches leave the flags unchanged.
- R9: The branch (0000) carries n, z, p masks in bits [11:9]. It jumps to the direct address if any masked flag is set. A mask of 000 never jumps.
- R10: A trap (1111) with bits [7:0] equal to x25 raises `halted` permanently, and no strobe follows. Any other trap vector, and the opcodes 0100, 1000, 1100 and 1101, change nothing and fall through to the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdata | input | 16 | Read word, valid one cycle after `mem_rd` |
| mem_rd | output | 1 | One-cycle memory read strobe |
| mem_wr | output | 1 | One-cycle memory write strobe |
| mem_addr | output | 16 | Word address, taken from the memory address register |
| mem_wdata | output | 16 | Write word, taken from the memory data register |
| halted | output | 1 | High once the halt trap has executed |

## Verification
The checker assumes the memory on the other side needs no wait states. It also assumes that reset is held across at least one clock edge, so that the state machine and the flag register start from defined values. The bench meets both conditions: its memory model answers every read at the next edge, and each scenario keeps reset asserted through the whole time the program is loaded. All programs are placed in the lowest 1024 words, and every address they form stays inside that window, so the ten-bit memory model never aliases an access.

// File: rtl/fx_pkg.sv
package fx_pkg;

  localparam int REG_N = 8;
  localparam int IDX_W = 3;

  typedef enum logic [3:0] {
    OP_BR   = 4'b0000,
    OP_ADD  = 4'b0001,
    OP_LD   = 4'b0010,
    OP_ST   = 4'b0011,
    OP_AND  = 4'b0101,
    OP_LDR  = 4'b0110,
    OP_STR  = 4'b0111,
    OP_NOT  = 4'b1001,
    OP_LDI  = 4'b1010,
    OP_STI  = 4'b1011,
    OP_LEA  = 4'b1110,
    OP_TRAP = 4'b1111
  } op_e;

  typedef enum logic [3:0] {
    S_FETCH, S_IF_RD, S_IF_CAP, S_IR_LD, S_DECODE, S_EXEC, S_EVAL,
    S_PTR_RD, S_PTR_CAP, S_PTR_MAR, S_OP_RD, S_OP_CAP, S_WB,
    S_ST_DATA, S_ST_WR, S_HALT
  } state_e;

  typedef enum logic [1:0] {MAR_PC, MAR_EA, MAR_MDR} mar_sel_e;
  typedef enum logic [1:0] {WB_ALU, WB_MDR, WB_EA} wb_sel_e;
  typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_NOT} alu_op_e;

  typedef struct packed {
    logic     ld_mar;
    mar_sel_e mar_sel;
    logic     ld_pc;
    logic     pc_from_ea;
    logic     ld_mdr;
    logic     mdr_from_reg;
    logic     ld_ir;
    logic     ld_reg;
    wb_sel_e  wb_sel;
    logic     ld_cc;
    logic     mem_rd;
    logic     mem_wr;
    logic     halt;
  } ctrl_t;

  function automatic logic is_store(op_e o);
    return (o == OP_ST) || (o == OP_STR) || (o == OP_STI);
  endfunction

  function automatic logic is_indirect(op_e o);
    return (o == OP_LDI) || (o == OP_STI);
  endfunction

endpackage

// File: rtl/fx_ctrl.sv
module fx_ctrl
  import fx_pkg::*;
#(
  parameter logic [7:0] HALT_VEC = 8'h25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  op_e        op,
  input  logic [7:0] vec,
  input  logic       br_hit,
  output ctrl_t      ctrl
);

  state_e st_q, st_d;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= S_FETCH;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d = st_q;
    ctrl = '0;
    case (st_q)
      S_FETCH: begin
        ctrl.ld_mar  = 1'b1;
        ctrl.mar_sel = MAR_PC;
        ctrl.ld_pc   = 1'b1;
        st_d         = S_IF_RD;
      end
      S_IF_RD: begin
        ctrl.mem_rd = 1'b1;
        st_d        = S_IF_CAP;
      end
      S_IF_CAP: begin
        ctrl.ld_mdr = 1'b1;
        st_d        = S_IR_LD;
      end
      S_IR_LD: begin
        ctrl.ld_ir = 1'b1;
        st_d       = S_DECODE;
      end
      S_DECODE: begin
        case (op)
          OP_ADD, OP_AND, OP_NOT, OP_LEA, OP_BR: st_d = S_EXEC;
          OP_LD, OP_ST, OP_LDR, OP_STR, OP_LDI, OP_STI: st_d = S_EVAL;
          OP_TRAP: st_d = (vec == HALT_VEC) ? S_HALT : S_FETCH;
          default: st_d = S_FETCH;
        endcase
      end
      S_EXEC: begin
        if (op == OP_BR) begin
          ctrl.ld_pc      = br_hit;
          ctrl.pc_from_ea = 1'b1;
        end else begin
          ctrl.ld_reg = 1'b1;
          ctrl.wb_sel = (op == OP_LEA) ? WB_EA : WB_ALU;
          ctrl.ld_cc  = 1'b1;
        end
        st_d = S_FETCH;
      end
      S_EVAL: begin
        ctrl.ld_mar  = 1'b1;
        ctrl.mar_sel = MAR_EA;
        if (is_indirect(op))   st_d = S_PTR_RD;
        else if (is_store(op)) st_d = S_ST_DATA;
        else                   st_d = S_OP_RD;
      end
      S_PTR_RD: begin
        ctrl.mem_rd = 1'b1;
        st_d        = S_PTR_CAP;
      end
      S_PTR_CAP: begin
        ctrl.ld_mdr = 1'b1;
        st_d        = S_PTR_MAR;
      end
      S_PTR_MAR: begin
        ctrl.ld_mar  = 1'b1;
        ctrl.mar_sel = MAR_MDR;
        st_d         = is_store(op) ? S_ST_DATA : S_OP_RD;
      end
      S_OP_RD: begin
        ctrl.mem_rd = 1'b1;
        st_d        = S_OP_CAP;
      end
      S_OP_CAP: begin
        ctrl.ld_mdr = 1'b1;
        st_d        = S_WB;
      end
      S_WB: begin
        ctrl.ld_reg = 1'b1;
        ctrl.wb_sel = WB_MDR;
        ctrl.ld_cc  = 1'b1;
        st_d        = S_FETCH;
      end
      S_ST_DATA: begin
        ctrl.ld_mdr       = 1'b1;
        ctrl.mdr_from_reg = 1'b1;
        st_d              = S_ST_WR;
      end
      S_ST_WR: begin
        ctrl.mem_wr = 1'b1;
        st_d        = S_FETCH;
      end
      S_HALT: begin
        ctrl.halt = 1'b1;
        st_d      = S_HALT;
      end
      default: st_d = S_FETCH;
    endcase
  end

endmodule

// File: rtl/fx_regs.sv
module fx_regs
  import fx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [IDX_W-1:0]  ra_a,
  input  logic [IDX_W-1:0]  ra_b,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);

  logic [REG_N-1:0][DATA_W-1:0] bank;

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                         q <= '0;
      else if (we && wa == IDX_W'(g))     q <= wd;
    end
    assign bank[g] = q;
  end

  assign rd_a = bank[ra_a];
  assign rd_b = bank[ra_b];

endmodule

// File: rtl/fx_alu.sv
module fx_alu
  import fx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_AND: y = a & b;
      ALU_NOT: y = ~a;
      default: y = a;
    endcase
  end

endmodule

// File: rtl/fx_agen.sv
module fx_agen #(
  parameter int DATA_W = 16,
  parameter int PG_W   = 9,
  parameter int OFS_W  = 6
) (
  input  logic [DATA_W-PG_W-1:0] pc_page,
  input  logic [PG_W-1:0]        pg_ofs,
  input  logic [DATA_W-1:0]      base,
  input  logic [OFS_W-1:0]       bo_ofs,
  input  logic                   base_mode,
  output logic [DATA_W-1:0]      ea
);

  logic [DATA_W-1:0] page_ea, base_ea;

  assign page_ea = {pc_page, pg_ofs};
  assign base_ea = base + {{(DATA_W-OFS_W){1'b0}}, bo_ofs};
  assign ea      = base_mode ? base_ea : page_ea;

endmodule

// File: rtl/fx_core.sv
module fx_core
  import fx_pkg::*;
#(
  parameter int                 DATA_W   = 16,
  parameter int                 PG_W     = 9,
  parameter int                 OFS_W    = 6,
  parameter int                 IMM_W    = 5,
  parameter logic [DATA_W-1:0]  RESET_PC = '0,
  parameter logic [7:0]         HALT_VEC = 8'h25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              halted
);

  localparam int OP_LSB = DATA_W - 4;
  localparam int DR_LSB = OP_LSB - IDX_W;
  localparam int SR_LSB = DR_LSB - IDX_W;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] pc_q, mar_q, mdr_q, ir_q;
  logic [2:0]        cc_q;
  op_e               op;
  logic [DATA_W-1:0] ra_val, rb_val, alu_b, alu_y, ea, wb_val;
  logic [IDX_W-1:0]  rb_idx;
  alu_op_e           alu_op;
  logic              br_hit;

  assign op     = op_e'(ir_q[DATA_W-1:OP_LSB]);
  assign br_hit = |(ir_q[OP_LSB-1:DR_LSB] & cc_q);

  fx_ctrl #(.HALT_VEC(HALT_VEC)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .vec    (ir_q[7:0]),
    .br_hit (br_hit),
    .ctrl   (ctrl)
  );

  assign rb_idx = is_store(op) ? ir_q[OP_LSB-1:DR_LSB] : ir_q[IDX_W-1:0];

  fx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (ctrl.ld_reg),
    .wa   (ir_q[OP_LSB-1:DR_LSB]),
    .wd   (wb_val),
    .ra_a (ir_q[DR_LSB-1:SR_LSB]),
    .ra_b (rb_idx),
    .rd_a (ra_val),
    .rd_b (rb_val)
  );

  always_comb begin
    case (op)
      OP_AND:  alu_op = ALU_AND;
      OP_NOT:  alu_op = ALU_NOT;
      default: alu_op = ALU_ADD;
    endcase
  end

  assign alu_b = ir_q[IMM_W] ? {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]}
                             : rb_val;

  fx_alu #(.DATA_W(DATA_W)) u_alu (
    .op(alu_op),
    .a (ra_val),
    .b (alu_b),
    .y (alu_y)
  );

  fx_agen #(.DATA_W(DATA_W), .PG_W(PG_W), .OFS_W(OFS_W)) u_agen (
    .pc_page  (pc_q[DATA_W-1:PG_W]),
    .pg_ofs   (ir_q[PG_W-1:0]),
    .base     (ra_val),
    .bo_ofs   (ir_q[OFS_W-1:0]),
    .base_mode((op == OP_LDR) || (op == OP_STR)),
    .ea       (ea)
  );

  always_comb begin
    case (ctrl.wb_sel)
      WB_MDR:  wb_val = mdr_q;
      WB_EA:   wb_val = ea;
      default: wb_val = alu_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      cc_q  <= 3'b010;
    end else begin
      if (ctrl.ld_mar) begin
        case (ctrl.mar_sel)
          MAR_PC:  mar_q <= pc_q;
          MAR_EA:  mar_q <= ea;
          default: mar_q <= mdr_q;
        endcase
      end
      if (ctrl.ld_pc)
        pc_q <= ctrl.pc_from_ea ? ea : pc_q + DATA_W'(1);
      if (ctrl.ld_mdr)
        mdr_q <= ctrl.mdr_from_reg ? rb_val : mem_rdata;
      if (ctrl.ld_ir)
        ir_q <= mdr_q;
      if (ctrl.ld_cc)
        cc_q <= wb_val[DATA_W-1] ? 3'b100 : ((wb_val == '0) ? 3'b010 : 3'b001);
    end
  end

  assign mem_rd    = ctrl.mem_rd;
  assign mem_wr    = ctrl.mem_wr;
  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign halted    = ctrl.halt;

endmodule

// File: rtl/fx_core_chk.sv
module fx_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       halted,
  input logic [2:0] cc
);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  // R4
  wr_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !$past(mem_rd));

  // R8
  cc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc) == 1);

  // R8
  cc_store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> $stable(cc));

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

endmodule

bind fx_core fx_core_chk u_fx_core_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .mem_rd(mem_rd),
  .mem_wr(mem_wr),
  .halted(halted),
  .cc    (cc_q)
);

// File: tb/fx_core_bench.sv
module fx_core_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_rdata;
  logic        mem_rd, mem_wr, halted;
  logic [15:0] mem_addr, mem_wdata;

  logic [15:0] mem [0:1023];
  logic        ld_en = 1'b0, clr_mem = 1'b0, cnt_clr = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;

  int rd_n, wr_n, cycles;
  logic [15:0] first_addr;
  logic saw_rd, prev_rd, prev_wr, long_strobe;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fx_core u_fx_core (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .halted(halted)
  );

  always @(posedge clk) begin
    if (clr_mem) begin
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
    end else if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end else if (mem_wr) begin
      mem[mem_addr[9:0]] <= mem_wdata;
    end
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
  end

  always @(posedge clk) begin
    if (cnt_clr) begin
      rd_n <= 0; wr_n <= 0; first_addr <= 16'hFFFF; saw_rd <= 0;
      prev_rd <= 0; prev_wr <= 0; long_strobe <= 0;
    end else begin
      if (mem_rd) begin
        rd_n <= rd_n + 1;
        if (!saw_rd) first_addr <= mem_addr;
        saw_rd <= 1'b1;
      end
      if (mem_wr) wr_n <= wr_n + 1;
      if ((mem_rd && prev_rd) || (mem_wr && prev_wr)) long_strobe <= 1'b1;
      prev_rd <= mem_rd;
      prev_wr <= mem_wr;
    end
  end

  initial cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] e_rr(input logic [3:0] op, input int d, input int s1, input int s2);
    return {op, 3'(d), 3'(s1), 3'b000, 3'(s2)};
  endfunction
  function automatic logic [15:0] e_ri(input logic [3:0] op, input int d, input int s1, input logic [4:0] imm);
    return {op, 3'(d), 3'(s1), 1'b1, imm};
  endfunction
  function automatic logic [15:0] e_not(input int d, input int s);
    return {4'b1001, 3'(d), 3'(s), 6'h3F};
  endfunction
  function automatic logic [15:0] e_pg(input logic [3:0] op, input int r, input logic [8:0] ofs);
    return {op, 3'(r), ofs};
  endfunction
  function automatic logic [15:0] e_bo(input logic [3:0] op, input int r, input int b, input logic [5:0] ofs);
    return {op, 3'(r), 3'(b), ofs};
  endfunction
  function automatic logic [15:0] e_br(input logic [2:0] nzp, input logic [8:0] ofs);
    return {4'b0000, nzp, ofs};
  endfunction
  function automatic logic [15:0] e_trap(input logic [7:0] v);
    return {8'hF0, v};
  endfunction

  task automatic poke(input int a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 10'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic prepare();
    @(negedge clk);
    rst_n = 1'b0;
    clr_mem = 1'b1;
    @(negedge clk);
    clr_mem = 1'b0;
  endtask

  task automatic launch(input string tag);
    @(negedge clk);
    // R1: outputs quiet while reset is held
    chk({tag, " R1 rd in reset"}, 16'(mem_rd), 16'h0);
    chk({tag, " R1 wr in reset"}, 16'(mem_wr), 16'h0);
    chk({tag, " R1 halted in reset"}, 16'(halted), 16'h0);
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    rst_n = 1'b1;
    begin
      int n = 0;
      while (!halted && n < 5000) begin
        @(negedge clk);
        n++;
      end
    end
    // R10: the halt trap stops the run
    chk({tag, " R10 halted"}, 16'(halted), 16'h1);
    // R1: first fetch at x0000
    chk({tag, " R1 first fetch"}, first_addr, 16'h0000);
    // R2: single-cycle strobes
    chk({tag, " R2 strobe width"}, 16'(long_strobe), 16'h0);
  endtask

  task automatic t_operate();
    prepare();
    poke(0, e_ri(4'b0001, 1, 0, 5'd5));
    poke(1, e_ri(4'b0001, 2, 0, 5'h1D));
    poke(2, e_rr(4'b0001, 3, 1, 2));
    poke(3, e_rr(4'b0101, 4, 3, 2));
    poke(4, e_not(5, 1));
    poke(5, e_ri(4'b0101, 6, 2, 5'h0F));
    poke(6, e_pg(4'b0011, 3, 9'h040));
    poke(7, e_pg(4'b0011, 4, 9'h041));
    poke(8, e_pg(4'b0011, 5, 9'h042));
    poke(9, e_pg(4'b0011, 6, 9'h043));
    poke(10, e_pg(4'b0011, 2, 9'h044));
    poke(11, e_trap(8'h25));
    launch("operate");
    chk("R3 add reg", mem[16'h40], 16'h0002);
    chk("R3 and reg", mem[16'h41], 16'h0000);
    chk("R3 not", mem[16'h42], 16'hFFFA);
    chk("R3 and imm", mem[16'h43], 16'h000D);
    chk("R3 add negative imm", mem[16'h44], 16'hFFFD);
    chk("R4 op read count", 16'(rd_n), 16'd12);
    chk("R4 op write count", 16'(wr_n), 16'd5);
  endtask

  task automatic t_loads();
    prepare();
    poke(16'h50, 16'h1234);
    poke(16'h51, 16'h0060);
    poke(16'h52, 16'h0080);
    poke(16'h60, 16'hBEEF);
    poke(16'h75, 16'h4242);
    poke(0, e_pg(4'b0010, 1, 9'h050));
    poke(1, e_pg(4'b1010, 2, 9'h051));
    poke(2, e_pg(4'b1110, 3, 9'h070));
    poke(3, e_bo(4'b0110, 4, 3, 6'd5));
    poke(4, e_bo(4'b0111, 1, 3, 6'd10));
    poke(5, e_pg(4'b1011, 4, 9'h052));
    poke(6, e_pg(4'b0011, 2, 9'h053));
    poke(7, e_pg(4'b0011, 3, 9'h054));
    poke(8, e_trap(8'h25));
    launch("loads");
    chk("R5 base load then base store", mem[16'h7A], 16'h1234);
    chk("R6 indirect store", mem[16'h80], 16'h4242);
    chk("R6 pointer untouched", mem[16'h52], 16'h0080);
    chk("R6 indirect load", mem[16'h53], 16'hBEEF);
    chk("R7 lea value", mem[16'h54], 16'h0070);
    chk("R7 R6 read count", 16'(rd_n), 16'd14);
    chk("R6 write count", 16'(wr_n), 16'd4);
  endtask

  task automatic t_page();
    prepare();
    poke(16'h010, 16'h1111);
    poke(16'h210, 16'h5A5A);
    poke(0, e_br(3'b111, 9'h1FE));
    poke(16'h1FE, e_ri(4'b0001, 0, 0, 5'd0));
    poke(16'h1FF, e_pg(4'b0010, 1, 9'h010));
    poke(16'h200, e_pg(4'b0011, 1, 9'h011));
    poke(16'h201, e_trap(8'h25));
    launch("page");
    chk("R4 page from incremented pc", mem[16'h211], 16'h5A5A);
    chk("R4 old page unused", mem[16'h011], 16'h0000);
  endtask

  task automatic t_branch();
    prepare();
    poke(16'h66, 16'h8000);
    poke(0,  e_br(3'b010, 9'd2));
    poke(1,  e_trap(8'h25));
    poke(2,  e_ri(4'b0001, 7, 0, 5'd1));
    poke(3,  e_br(3'b100, 9'd5));
    poke(4,  e_pg(4'b0011, 7, 9'h060));
    poke(5,  e_br(3'b001, 9'd7));
    poke(6,  e_pg(4'b0011, 7, 9'h061));
    poke(7,  e_ri(4'b0001, 1, 0, 5'h1F));
    poke(8,  e_pg(4'b0011, 1, 9'h062));
    poke(9,  e_br(3'b100, 9'd11));
    poke(10, e_pg(4'b0011, 7, 9'h063));
    poke(11, e_ri(4'b0101, 2, 2, 5'd0));
    poke(12, e_br(3'b101, 9'd14));
    poke(13, e_pg(4'b0011, 7, 9'h064));
    poke(14, e_br(3'b000, 9'd16));
    poke(15, e_pg(4'b0011, 7, 9'h065));
    poke(16, e_pg(4'b0010, 3, 9'h066));
    poke(17, e_br(3'b011, 9'd19));
    poke(18, e_pg(4'b0011, 7, 9'h067));
    poke(19, e_trap(8'h25));
    launch("branch");
    chk("R8 reset zero flag branch", 16'(rd_n > 2), 16'h1);
    chk("R9 not taken n", mem[16'h60], 16'h0001);
    chk("R9 taken p", mem[16'h61], 16'h0000);
    chk("R8 store value", mem[16'h62], 16'hFFFF);
    chk("R8 store keeps n", mem[16'h63], 16'h0000);
    chk("R9 nz-p on zero not taken", mem[16'h64], 16'h0001);
    chk("R9 empty mask", mem[16'h65], 16'h0001);
    chk("R8 load sets n", mem[16'h67], 16'h0001);
  endtask

  task automatic t_trap();
    int rd_at_halt;
    prepare();
    poke(0, e_trap(8'h21));
    poke(1, 16'hD000);
    poke(2, e_ri(4'b0001, 1, 0, 5'd7));
    poke(3, e_pg(4'b0011, 1, 9'h040));
    poke(4, e_trap(8'h25));
    poke(5, e_pg(4'b0011, 1, 9'h041));
    launch("trap");
    chk("R10 fallthrough", mem[16'h40], 16'h0007);
    chk("R10 nothing after halt", mem[16'h41], 16'h0000);
    rd_at_halt = rd_n;
    repeat (20) @(negedge clk);
    chk("R10 quiet reads", 16'(rd_n), 16'(rd_at_halt));
    chk("R10 fetch count", 16'(rd_n), 16'd5);
    chk("R10 still halted", 16'(halted), 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_operate();
    t_loads();
    t_page();
    t_branch();
    t_trap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule